// File: doc/BRIEF.md
# Protected Message Transmit Framer

This block turns one message from an 8-bit parallel bus into a serial bit stream on a single output line. It fetches every byte it sends with a one-cycle strobe. The message is built in this order: an optional start bit, an optional size byte, the data bytes, and a cyclic check word. The check word is computed bit by bit while the size and data bytes go out.

There are two line modes. In the clocked mode one bit goes out per clock and a one-cycle sync strobe marks the first bit. In the sampled mode a leading zero start bit comes first and each bit lasts `OVERSAMPLE` clocks. The message length is either fixed at 2, 4 or 6 bytes, or set per message by a parity-protected size byte. The check word is 7 or 15 bits long. A request pulse starts a message. The busy output covers the whole message and can be used to end the request.

Top module: `msg_tx_framer`

## Requirements
- R1: While reset is high and after its release, with no request, the line is high and busy, the data strobe and the sync strobe are low.
- R2: With `asyncMode` high when the request is taken, the line is low for one bit period, starting the cycle after the request edge, before the first byte bit.
- R3: With `asyncMode` low there is no start bit, and `msgSync` is high for exactly the first bit cycle of the message.
- R4: `lenSel` values 1, 2 and 3 send 2, 4 and 6 data bytes with no size byte; value 0 sends a size byte and then the count of data bytes it carries.
- R5: For a size byte, the bus bit 0 is C, bit 1 is B and bit 2 is A, and count = 4C+2B+A. The byte sent keeps bits 0..2, puts C xor B xor A on bit 3, and sends bits 7..4 as zero whatever the bus holds.
- R6: A size count of zero sends the size byte followed directly by the check word, with no further fetch.
- R7: The check word uses a zero preset and covers every bit of the size and data bytes. It is 7 bits with polynomial x^7+x^3+1 when `longCheck` is low, and 15 bits with x^15+x^14+x^10+x^8+x^7+x^4+x^3+1 when it is high. It is sent highest register bit first.
- R8: `dataStrobe` is high for one cycle per byte sent, and the bus is sampled at the clock edge ending that cycle. It is high in the request cycle for the clocked mode, in the last cycle of the start bit for the sampled mode, and in the last cycle of the previous byte otherwise.
- R9: Bytes go out LSB first, one bit per clock in the clocked mode and one bit per `OVERSAMPLE` clocks in the sampled mode.
- R10: Busy is high from the cycle after the request edge through the last check bit, then the line returns high. A request held high during busy does not alter the message in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; bit clock in clocked mode, sample clock in sampled mode |
| rst | input | 1 | Synchronous active-high reset |
| startReq | input | 1 | Message request, taken while idle |
| lenSel | input | 2 | Length select: 0 variable, 1/2/3 for 2/4/6 bytes |
| longCheck | input | 1 | High selects the 15-bit check word, low the 7-bit one |
| asyncMode | input | 1 | High selects the sampled mode with start bit |
| busIn | input | 8 | Parallel byte source |
| msgOut | output | 1 | Serial message line, high when idle |
| msgSync | output | 1 | First-bit marker in clocked mode |
| busy | output | 1 | Message in progress |
| dataStrobe | output | 1 | Byte fetch strobe |

## Verification
The hardest case to reach is the hand-off at a byte boundary. There, the fetch strobe, the last data bit entering the check register and the loading of the check word all fall on one clock edge. At that edge an off-by-one mistake corrupts the trailer without disturbing any data bit. The bench sweeps both modes, both check lengths, every fixed length and every size count from 0 to 7, so that the data-to-check hand-off happens after a size byte, after a short message and after a long one. The bench changes the bus only in the cycle after each strobe it observes, and it puts junk in the upper bits of the size byte, so that a fetch taken early or late, or a size byte that is not rebuilt, shows up as a miscompare.

// File: rtl/msg_tx_pkg.sv
package msg_tx_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_SIZE,
    ST_DATA,
    ST_CHECK
  } txState_t;

  // Strobes from the control into the datapath
  typedef struct packed {
    logic crcClear;
    logic crcStep;
    logic loadByte;
    logic loadSize;
    logic loadCheck;
    logic shiftBit;
  } dpCtrl_t;

endpackage

// File: rtl/msg_tx_ctrl.sv
module msg_tx_ctrl
  import msg_tx_pkg::*;
#(
  parameter int OVERSAMPLE = 32,
  parameter int SHORT_W    = 7,
  parameter int LONG_W     = 15
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       startReq,
  input  logic [1:0] lenSel,
  input  logic       longCheck,
  input  logic       asyncMode,
  input  logic [2:0] sizeCount,
  output dpCtrl_t    dpCtrl,
  output logic       longQ,
  output logic       inStart,
  output logic       busy,
  output logic       msgSync,
  output logic       dataStrobe
);

  localparam int TICK_W = (OVERSAMPLE > 1) ? $clog2(OVERSAMPLE) : 1;
  localparam int BIT_W  = $clog2(LONG_W + 1);

  txState_t          state, stateN;
  logic [TICK_W-1:0] tick;
  logic [BIT_W-1:0]  bitCnt;
  logic [BIT_W-1:0]  elemLen;
  logic [2:0]        bytesLeft, bytesLeftN;
  logic              asyncQ;
  logic [1:0]        lenQ, lenEff;
  logic              bitEnd, lastBit, firstFetch, frameGo;

  assign busy    = (state != ST_IDLE);
  assign inStart = (state == ST_START);
  assign lenEff  = (state == ST_IDLE) ? lenSel : lenQ;
  assign bitEnd  = !asyncQ || (tick == TICK_W'(OVERSAMPLE - 1));

  always_comb begin
    case (state)
      ST_START: elemLen = BIT_W'(1);
      ST_CHECK: elemLen = longQ ? BIT_W'(LONG_W) : BIT_W'(SHORT_W);
      default:  elemLen = BIT_W'(8);
    endcase
  end

  assign lastBit = bitEnd && (bitCnt == elemLen - BIT_W'(1));

  always_comb begin
    dpCtrl     = '0;
    dataStrobe = 1'b0;
    stateN     = state;
    bytesLeftN = bytesLeft;
    firstFetch = 1'b0;
    frameGo    = 1'b0;
    case (state)
      ST_IDLE: begin
        if (startReq) begin
          frameGo         = 1'b1;
          dpCtrl.crcClear = 1'b1;
          if (asyncMode) stateN = ST_START;
          else firstFetch = 1'b1;
        end
      end
      ST_START: begin
        if (lastBit) firstFetch = 1'b1;
      end
      ST_SIZE, ST_DATA: begin
        if (bitEnd) begin
          dpCtrl.crcStep = 1'b1;
          if (lastBit) begin
            if (bytesLeft != 3'd0) begin
              dpCtrl.loadByte = 1'b1;
              dataStrobe      = 1'b1;
              bytesLeftN      = bytesLeft - 3'd1;
              stateN          = ST_DATA;
            end else begin
              dpCtrl.loadCheck = 1'b1;
              stateN           = ST_CHECK;
            end
          end else begin
            dpCtrl.shiftBit = 1'b1;
          end
        end
      end
      ST_CHECK: begin
        if (bitEnd) begin
          if (lastBit) stateN = ST_IDLE;
          else dpCtrl.shiftBit = 1'b1;
        end
      end
      default: stateN = ST_IDLE;
    endcase
    if (firstFetch) begin
      dataStrobe = 1'b1;
      if (lenEff == 2'd0) begin
        dpCtrl.loadSize = 1'b1;
        bytesLeftN      = sizeCount;
        stateN          = ST_SIZE;
      end else begin
        dpCtrl.loadByte = 1'b1;
        bytesLeftN      = {lenEff, 1'b0} - 3'd1;
        stateN          = ST_DATA;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      tick      <= '0;
      bitCnt    <= '0;
      bytesLeft <= '0;
      asyncQ    <= 1'b0;
      lenQ      <= '0;
      longQ     <= 1'b0;
      msgSync   <= 1'b0;
    end else begin
      state     <= stateN;
      bytesLeft <= bytesLeftN;
      msgSync   <= frameGo && !asyncMode;
      if (state == ST_IDLE || bitEnd) tick <= '0;
      else tick <= tick + TICK_W'(1);
      if (state == ST_IDLE || lastBit) bitCnt <= '0;
      else if (bitEnd) bitCnt <= bitCnt + BIT_W'(1);
      if (frameGo) begin
        asyncQ <= asyncMode;
        lenQ   <= lenSel;
        longQ  <= longCheck;
      end
    end
  end

  AST_STROBE_ONESHOT: assert property (@(posedge clk) disable iff (rst)
    dataStrobe |=> !dataStrobe); // R8
  AST_SYNC_PULSE: assert property (@(posedge clk) disable iff (rst)
    msgSync |=> !msgSync); // R3
  AST_SYNC_NO_START: assert property (@(posedge clk) disable iff (rst)
    msgSync |-> (busy && !inStart)); // R3
  AST_BUSY_FROM_REQ: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(startReq)); // R10

endmodule

// File: rtl/msg_tx_datapath.sv
module msg_tx_datapath
  import msg_tx_pkg::*;
#(
  parameter int               SHORT_W    = 7,
  parameter int               LONG_W     = 15,
  parameter logic [LONG_W-1:0] SHORT_POLY = 15'h0009,
  parameter logic [LONG_W-1:0] LONG_POLY  = 15'h4599
) (
  input  logic       clk,
  input  logic       rst,
  input  dpCtrl_t    dpCtrl,
  input  logic       longQ,
  input  logic       inStart,
  input  logic       busy,
  input  logic [7:0] busIn,
  output logic [2:0] sizeCount,
  output logic       lineOut
);

  localparam int SH_W = (LONG_W > 8) ? LONG_W : 8;
  localparam logic [LONG_W-1:0] SHORT_MASK = LONG_W'((1 << SHORT_W) - 1);

  logic [SH_W-1:0]   shreg;
  logic [LONG_W-1:0] crc, crcNext, crcShift, crcRev, polySel;
  logic [7:0]        sizeByte;
  logic              crcTop, fb;

  // bus bit0 = C, bit1 = B, bit2 = A ; count = 4C + 2B + A
  assign sizeCount = {busIn[0], busIn[1], busIn[2]};
  assign sizeByte  = {4'b0000, ^busIn[2:0], busIn[2:0]};

  assign crcTop   = longQ ? crc[LONG_W-1] : crc[SHORT_W-1];
  assign fb       = shreg[0] ^ crcTop;
  assign crcShift = {crc[LONG_W-2:0], 1'b0} & (longQ ? {LONG_W{1'b1}} : SHORT_MASK);
  assign polySel  = longQ ? LONG_POLY : SHORT_POLY;
  assign crcNext  = crcShift ^ (fb ? polySel : '0);

  always_comb begin
    crcRev = '0;
    for (int i = 0; i < LONG_W; i++) begin
      if (longQ) crcRev[i] = crcNext[LONG_W-1-i];
      else if (i < SHORT_W) crcRev[i] = crcNext[SHORT_W-1-i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      crc   <= '0;
      shreg <= '0;
    end else begin
      if (dpCtrl.crcClear) crc <= '0;
      else if (dpCtrl.crcStep) crc <= crcNext;
      if (dpCtrl.loadByte) shreg <= SH_W'(busIn);
      else if (dpCtrl.loadSize) shreg <= SH_W'(sizeByte);
      else if (dpCtrl.loadCheck) shreg <= SH_W'(crcRev);
      else if (dpCtrl.shiftBit) shreg <= shreg >> 1;
    end
  end

  assign lineOut = !busy ? 1'b1 : (inStart ? 1'b0 : shreg[0]);

  AST_SIZE_PARITY: assert property (@(posedge clk) disable iff (rst)
    dpCtrl.loadSize |=> (shreg[3] == ^shreg[2:0]) && (shreg[SH_W-1:4] == '0)); // R5
  AST_SHORT_CHECK_FIT: assert property (@(posedge clk) disable iff (rst)
    (dpCtrl.loadCheck && !longQ) |=> (shreg[SH_W-1:SHORT_W] == '0)); // R7

endmodule

// File: rtl/msg_tx_framer.sv
module msg_tx_framer
  import msg_tx_pkg::*;
#(
  parameter int OVERSAMPLE = 32
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       startReq,
  input  logic [1:0] lenSel,
  input  logic       longCheck,
  input  logic       asyncMode,
  input  logic [7:0] busIn,
  output logic       msgOut,
  output logic       msgSync,
  output logic       busy,
  output logic       dataStrobe
);

  localparam int SHORT_W = 7;
  localparam int LONG_W  = 15;

  dpCtrl_t    dpCtrl;
  logic       longQ, inStart;
  logic [2:0] sizeCount;

  msg_tx_ctrl #(
    .OVERSAMPLE(OVERSAMPLE), .SHORT_W(SHORT_W), .LONG_W(LONG_W)
  ) ctrl_i (
    .clk(clk), .rst(rst), .startReq(startReq), .lenSel(lenSel),
    .longCheck(longCheck), .asyncMode(asyncMode), .sizeCount(sizeCount),
    .dpCtrl(dpCtrl), .longQ(longQ), .inStart(inStart), .busy(busy),
    .msgSync(msgSync), .dataStrobe(dataStrobe)
  );

  msg_tx_datapath #(
    .SHORT_W(SHORT_W), .LONG_W(LONG_W)
  ) dp_i (
    .clk(clk), .rst(rst), .dpCtrl(dpCtrl), .longQ(longQ),
    .inStart(inStart), .busy(busy), .busIn(busIn),
    .sizeCount(sizeCount), .lineOut(msgOut)
  );

endmodule

// File: tb/msg_tx_framer_tb_top.sv
module msg_tx_framer_tb_top;

  logic       clk = 1'b0;
  logic       rst, startReq, longCheck, asyncMode;
  logic [1:0] lenSel;
  logic [7:0] busIn;
  logic       msgOut, msgSync, busy, dataStrobe;

  always #10 clk = ~clk;

  msg_tx_framer dut_i (
    .clk(clk), .rst(rst), .startReq(startReq), .lenSel(lenSel),
    .longCheck(longCheck), .asyncMode(asyncMode), .busIn(busIn),
    .msgOut(msgOut), .msgSync(msgSync), .busy(busy), .dataStrobe(dataStrobe)
  );

  int vectors = 0;
  int miscompares = 0;
  bit done = 0;

  logic       expBits[128];
  bit         byteStart[129];
  string      bitTag[128];
  logic [7:0] fetchBytes[16];
  logic [7:0] sentBytes[16];

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic runFrame(input bit am, input logic [1:0] ls, input bit lng,
                          input int n, input int seed, input int hold);
    int nData, nb, nf, bitLen, fi, strobes, w;
    logic [14:0] c;
    logic [2:0] nn;
    logic [7:0] v;
    bit prevStrobe, expS, b, fbk;
    bitLen = am ? 32 : 1;
    nData  = (ls == 2'd0) ? n : 2 * int'(ls);
    nf = 0;
    nn = 3'(n);
    if (ls == 2'd0) begin
      // bus bit0 = C = count bit 2, bit1 = B, bit2 = A = count bit 0
      fetchBytes[nf] = {5'(seed) ^ 5'b10101, nn[0], nn[1], nn[2]};
      sentBytes[nf]  = {4'b0000, ^nn, nn[0], nn[1], nn[2]};
      nf++;
    end
    for (int k = 0; k < nData; k++) begin
      v = 8'(seed * 29 + k * 53 + 7);
      fetchBytes[nf] = v;
      sentBytes[nf]  = v;
      nf++;
    end
    nb = 0;
    if (am) begin
      expBits[0] = 1'b0; bitTag[0] = "R2 start bit"; byteStart[0] = 1'b0; nb = 1;
    end
    c = '0;
    for (int j = 0; j < nf; j++) begin
      for (int i = 0; i < 8; i++) begin
        b = sentBytes[j][i];
        expBits[nb]   = b;
        bitTag[nb]    = (ls == 2'd0 && j == 0) ? "R5 size bit" : "R9 data bit";
        byteStart[nb] = (i == 0);
        fbk = b ^ (lng ? c[14] : c[6]);
        c = {c[13:0], 1'b0} & (lng ? 15'h7fff : 15'h007f);
        if (fbk) c = c ^ (lng ? 15'h4599 : 15'h0009);
        nb++;
      end
    end
    w = lng ? 15 : 7;
    for (int i = w - 1; i >= 0; i--) begin
      expBits[nb] = c[i]; bitTag[nb] = "R7 check bit"; byteStart[nb] = 1'b0; nb++;
    end
    byteStart[nb] = 1'b0;

    @(negedge clk);
    busIn = fetchBytes[0];
    startReq = 1'b1; asyncMode = am; lenSel = ls; longCheck = lng;
    #1;
    chk("R8 strobe in request cycle", dataStrobe, am ? 1'b0 : byteStart[0]);
    chk("R10 busy before first edge", busy, 1'b0);
    prevStrobe = dataStrobe;
    strobes = dataStrobe ? 1 : 0;
    fi = 0;
    for (int t = 0; t < nb * bitLen; t++) begin
      @(negedge clk);
      if (t == hold) startReq = 1'b0;
      if (prevStrobe) begin
        fi++;
        busIn = (fi < nf) ? fetchBytes[fi] : 8'hA5;
      end
      #1;
      chk(bitTag[t / bitLen], msgOut, expBits[t / bitLen]);
      chk("R10 busy during message", busy, 1'b1);
      expS = ((t + 1) % bitLen == 0) && byteStart[(t + 1) / bitLen];
      chk("R8 strobe timing", dataStrobe, expS);
      chk("R3 sync strobe", msgSync, (!am && t == 0));
      prevStrobe = dataStrobe;
      if (dataStrobe) strobes++;
    end
    chk((ls == 2'd0 && n == 0) ? "R6 fetch count" : "R4 fetch count", 16'(strobes), 16'(nf));
    @(negedge clk); #1;
    chk("R10 busy released", busy, 1'b0);
    chk("R10 idle line", msgOut, 1'b1);
    chk("R8 no strobe idle", dataStrobe, 1'b0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    int seed;
    rst = 1'b1; startReq = 1'b0; lenSel = 2'd0; longCheck = 1'b0;
    asyncMode = 1'b0; busIn = 8'h00;
    repeat (3) @(negedge clk);
    #1;
    chk("R1 line in reset", msgOut, 1'b1);
    chk("R1 busy in reset", busy, 1'b0);
    chk("R1 strobe in reset", dataStrobe, 1'b0);
    chk("R1 sync in reset", msgSync, 1'b0);
    @(negedge clk); rst = 1'b0;
    repeat (2) @(negedge clk);
    #1;
    chk("R1 line after reset", msgOut, 1'b1);
    chk("R1 busy after reset", busy, 1'b0);
    chk("R1 sync after reset", msgSync, 1'b0);
    seed = 1;
    for (int am = 0; am < 2; am++) begin
      for (int lng = 0; lng < 2; lng++) begin
        for (int ls = 1; ls < 4; ls++) begin
          runFrame(am[0], 2'(ls), lng[0], 0, seed, seed % 3);
          seed++;
        end
        for (int n = 0; n < 8; n++) begin
          runFrame(am[0], 2'd0, lng[0], n, seed, seed % 3);
          seed++;
        end
      end
    end
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule